// File: doc/BRIEF.md
# Grouped pin interrupt aggregator

This block turns a wide vector of general-purpose input pins into interrupt sources and folds them into a single parent interrupt line. Pins are handled in banks of eight. For every pin, software picks a trigger condition, a mask bit and a pending bit. Each bank has three 32-bit words: a trigger-control word, a mask word and a pending word. These words are reached through a small 32-bit register bus.

Every pin passes through a two-stage synchroniser. It is then compared with its own registered previous value, which gives edge detection. A detected condition latches the pending bit whether or not the pin is masked. The parent interrupt is raised while any pending bit has a clear mask bit. Software acknowledges one pin by writing a one to that pin's position in the bank's pending word.

The number of banks is a parameter. Reads return data one clock after the address is presented.

Top module: `gpio_irq_agg`

## Requirements
- R1: Bank g's trigger-control word sits at byte address 0x700+4g, its mask word at 0x900+4g and its pending word at 0xA00+4g. A read presents the addressed word on `bus_rdata` one clock edge after the address is applied.
- R2: Pin n of a bank uses bit n of the mask and pending words. Its trigger code is held in bits [4n+2:4n] of the control word. Bit 4n+3 always reads 0, and writes to it are dropped.
- R3: Trigger codes are 0 = input low, 1 = input high, 2 = falling edge, 3 = rising edge, 4 = either edge. Codes 5, 6 and 7 never set the pending bit. An edge mode ignores the opposite edge.
- R4: A pin change applied before clock edge 1 sets its pending bit at edge 3. If the pin is unmasked, the parent interrupt follows at edge 4.
- R5: Pending words are write-one-to-clear. A zero bit in the written data leaves that pending bit as it was. When a trigger and a clear hit the same bit in the same cycle, the bit stays set.
- R6: In the two level modes, the pending bit is set again on every cycle while the active level lasts. A clear only holds once the input has returned to its inactive level.
- R7: `irq_out` is high exactly when some pending bit has its mask bit at 0, with one cycle of delay. A masked pin still latches its pending bit, and software can read that bit.
- R8: Reset is synchronous and active high. It sets every mask bit to 1, every pending bit to 0, every trigger field to 0, and clears `irq_out` and `bus_rdata`.
- R9: Reads of unmapped, unaligned or out-of-range addresses return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pins_in | input | 8*NUM_GROUPS | Asynchronous pin inputs, bank g pin n at bit 8g+n |
| irq_out | output | 1 | Registered parent interrupt |

## Verification
A wrong trigger field, mask bit or pending bit shows up in two places. It appears on `irq_out` on the clock edge after the bad state arises, and on `bus_rdata` one edge after the affected word is addressed. The bench keeps a behavioural model of every bank and compares both outputs on every cycle, so a fault is reported within a cycle or two of when it begins. Directed sequences place edges, levels and acknowledges at exact cycles to expose the same-cycle set-versus-clear race and the synchroniser latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int LANES    = 8;
  localparam int FIELD_W  = 4;
  localparam int CODE_W   = 3;

  localparam logic [3:0]  PAGE_CTRL  = 4'h7;
  localparam logic [3:0]  PAGE_MASK  = 4'h9;
  localparam logic [3:0]  PAGE_PEND  = 4'hA;
  localparam logic [31:0] CTRL_KEEP  = 32'h7777_7777;

  typedef enum logic [CODE_W-1:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_ANY  = 3'd4
  } trig_e;

  function automatic logic trig_hit(input logic [CODE_W-1:0] code,
                                    input logic now, input logic was);
    case (code)
      TRIG_LOW:  return ~now;
      TRIG_HIGH: return now;
      TRIG_FALL: return was & ~now;
      TRIG_RISE: return ~was & now;
      TRIG_ANY:  return was ^ now;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] now_q,
  output logic [W-1:0] was_q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      now_q  <= '0;
      was_q  <= '0;
    end else begin
      meta_q <= d;
      now_q  <= meta_q;
      was_q  <= now_q;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] now_i,
  input  logic [LANES-1:0] was_i,
  input  logic             ctrl_we,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctrl_q,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] pend_q
);

  logic [LANES-1:0] hit;
  logic [LANES-1:0] clr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = trig_hit(ctrl_q[FIELD_W*i +: CODE_W], now_i[i], was_i[i]);
  end

  assign clr = clr_we ? wdata[LANES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata & CTRL_KEEP;
      if (mask_we) mask_q <= wdata[LANES-1:0];
      pend_q <= (pend_q & ~clr) | hit;
    end
  end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [LANES*NUM_GROUPS-1:0] pins_in,
  output logic                        irq_out
);

  localparam int NPINS  = LANES * NUM_GROUPS;
  localparam int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [NPINS-1:0]        pin_now, pin_was;
  logic [32*NUM_GROUPS-1:0] ctrl_all;
  logic [NPINS-1:0]        mask_all, pend_all;
  logic [NUM_GROUPS-1:0]   ctrl_we, mask_we, clr_we;
  logic                    clr_any;

  logic [3:0]        page;
  logic [5:0]        widx;
  logic [GIDX_W-1:0] gsel;
  logic              addr_ok;
  logic [31:0]       rd_next;
  logic [31:0]       rdata_q;
  logic              irq_q;

  gpio_irq_sync #(.W(NPINS)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .d     (pins_in),
    .now_q (pin_now),
    .was_q (pin_was)
  );

  assign page    = bus_addr[11:8];
  assign widx    = bus_addr[7:2];
  assign gsel    = widx[GIDX_W-1:0];
  assign addr_ok = (bus_addr[1:0] == 2'b00)
                && ((bus_addr >> 12) == '0)
                && ({26'd0, widx} < 32'(NUM_GROUPS));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    logic sel;
    assign sel        = bus_we && addr_ok && (gsel == GIDX_W'(g));
    assign ctrl_we[g] = sel && (page == PAGE_CTRL);
    assign mask_we[g] = sel && (page == PAGE_MASK);
    assign clr_we[g]  = sel && (page == PAGE_PEND);

    gpio_irq_bank bank_i (
      .clk     (clk),
      .rst     (rst),
      .now_i   (pin_now[LANES*g +: LANES]),
      .was_i   (pin_was[LANES*g +: LANES]),
      .ctrl_we (ctrl_we[g]),
      .mask_we (mask_we[g]),
      .clr_we  (clr_we[g]),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_all[32*g +: 32]),
      .mask_q  (mask_all[LANES*g +: LANES]),
      .pend_q  (pend_all[LANES*g +: LANES])
    );
  end

  assign clr_any = |clr_we;

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (addr_ok && gsel == GIDX_W'(g)) begin
        case (page)
          PAGE_CTRL: rd_next = ctrl_all[32*g +: 32];
          PAGE_MASK: rd_next = {24'd0, mask_all[LANES*g +: LANES]};
          PAGE_PEND: rd_next = {24'd0, pend_all[LANES*g +: LANES]};
          default:   rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_next;
      irq_q   <= |(pend_all & ~mask_all);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [32*NUM_GROUPS-1:0]    ctrl_all,
  input logic [LANES*NUM_GROUPS-1:0] mask_all,
  input logic [LANES*NUM_GROUPS-1:0] pend_all,
  input logic [LANES*NUM_GROUPS-1:0] pin_now,
  input logic                        clr_any,
  input logic                        irq_out
);

  localparam int NPINS = LANES * NUM_GROUPS;

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> ((&mask_all) && pend_all == '0 && ctrl_all == '0 && !irq_out));

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend_all & ~mask_all)) |=> irq_out);

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_all & ~mask_all)) |=> !irq_out);

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_any |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_all & ~{NUM_GROUPS{CTRL_KEEP}}) == '0);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int G = i / LANES;
    localparam int N = i % LANES;
    logic [CODE_W-1:0] code;
    assign code = ctrl_all[32*G + FIELD_W*N +: CODE_W];

    // R6
    level_high_chk: assert property (@(posedge clk) disable iff (rst)
      (code == 3'd1 && pin_now[i]) |=> pend_all[i]);

    // R3
    disabled_code_chk: assert property (@(posedge clk) disable iff (rst)
      (code >= 3'd5 && !pend_all[i]) |=> !pend_all[i]);
  end

endmodule

bind gpio_irq_agg gpio_irq_chk #(.NUM_GROUPS(NUM_GROUPS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ctrl_all (ctrl_all),
  .mask_all (mask_all),
  .pend_all (pend_all),
  .pin_now  (pin_now),
  .clr_any  (clr_any),
  .irq_out  (irq_out)
);

// File: tb/gpio_irq_agg_tb_top.sv
module gpio_irq_agg_tb_top;

  localparam int NG = 4;
  localparam int NP = 8 * NG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pins = '1;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_agg #(.NUM_GROUPS(NG), .ADDR_W(12)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_in   (pins),
    .irq_out   (irq_out)
  );

  // Behavioural reference model
  logic [31:0]   m_ctrl [NG];
  logic [7:0]    m_mask [NG];
  logic [7:0]    m_pend [NG];
  logic [NP-1:0] m_s1, m_s2, m_pv;
  logic [31:0]   m_rd;
  logic          m_irq;

  function automatic bit code_fires(int code, bit now, bit was);
    if (code == 0) return !now;
    if (code == 1) return now;
    if (code == 2) return was && !now;
    if (code == 3) return !was && now;
    if (code == 4) return was != now;
    return 0;
  endfunction

  // returns region 0 ctrl, 1 mask, 2 pend, -1 none; idx = bank
  function automatic int region(int a, output int idx);
    idx = 0;
    if (a % 4 != 0) return -1;
    if (a >= 'h700 && a < 'h700 + 4*NG) begin idx = (a - 'h700)/4; return 0; end
    if (a >= 'h900 && a < 'h900 + 4*NG) begin idx = (a - 'h900)/4; return 1; end
    if (a >= 'hA00 && a < 'hA00 + 4*NG) begin idx = (a - 'hA00)/4; return 2; end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NG; g++) begin
        m_ctrl[g] = '0; m_mask[g] = 8'hFF; m_pend[g] = '0;
      end
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_rd = '0; m_irq = 0;
    end else begin
      int a, idx, r;
      logic [7:0] np [NG];
      bit any;
      a = int'(bus_addr);
      r = region(a, idx);
      any = 0;
      for (int g = 0; g < NG; g++) if ((m_pend[g] & ~m_mask[g]) != 0) any = 1;
      m_irq = any;
      m_rd = 0;
      if (r == 0) m_rd = m_ctrl[idx];
      else if (r == 1) m_rd = {24'd0, m_mask[idx]};
      else if (r == 2) m_rd = {24'd0, m_pend[idx]};
      for (int g = 0; g < NG; g++) begin
        np[g] = m_pend[g];
        if (bus_we && r == 2 && idx == g) np[g] = np[g] & ~bus_wdata[7:0];
        for (int n = 0; n < 8; n++) begin
          int code;
          code = int'(m_ctrl[g][4*n +: 3]);
          if (code_fires(code, m_s2[8*g+n], m_pv[8*g+n])) np[g][n] = 1'b1;
        end
      end
      if (bus_we && r == 0) m_ctrl[idx] = bus_wdata & 32'h7777_7777;
      if (bus_we && r == 1) m_mask[idx] = bus_wdata[7:0];
      for (int g = 0; g < NG; g++) m_pend[g] = np[g];
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R1 model read data: actual %h expected %h", bus_rdata, m_rd);
      end
      if (irq_out !== m_irq) begin
        errors++;
        $display("FAIL R7 model irq: actual %0b expected %0b", irq_out, m_irq);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R8 irq in reset", {31'd0, irq_out}, 32'd0);
    chk("R8 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    idle(5);
    for (int g = 0; g < NG; g++) begin
      rd(12'(12'h900 + 4*g), 32'hFF, "R8 mask reset");
      rd(12'(12'h700 + 4*g), 32'h0, "R8 ctrl reset");
    end
    for (int g = 0; g < NG; g++) wr(12'(12'h700 + 4*g), 32'h5555_5555);
    for (int g = 0; g < NG; g++) wr(12'(12'hA00 + 4*g), 32'hFF);
    for (int g = 0; g < NG; g++) rd(12'(12'hA00 + 4*g), 32'h0, "R5 clear all");

    // R2 spare bits
    wr(12'h704, 32'hFFFF_FFFF);
    rd(12'h704, 32'h7777_7777, "R2 spare field bits");
    wr(12'h704, 32'h5555_5555);
    rd(12'h704, 32'h5555_5555, "R1 ctrl readback");

    // R3/R4 rising edge on bank 0 pin 3
    wr(12'h700, 32'h5555_3555);
    wr(12'h900, 32'hF7);
    pins[3] = 1'b0;
    idle(5);
    rd(12'hA00, 32'h0, "R3 rising ignores fall");
    @(negedge clk); pins[3] = 1'b1;
    idle(3);
    chk("R4 irq not yet at edge 3", {31'd0, irq_out}, 32'd0);
    idle(1);
    chk("R4 irq at edge 4", {31'd0, irq_out}, 32'd1);
    rd(12'hA00, 32'h08, "R3 rising sets pin 3");

    // R5 write-one-to-clear
    wr(12'hA00, 32'h00);
    rd(12'hA00, 32'h08, "R5 zero write keeps bit");
    wr(12'hA00, 32'h08);
    rd(12'hA00, 32'h00, "R5 one write clears bit");
    idle(2);
    chk("R7 irq drops after clear", {31'd0, irq_out}, 32'd0);

    // R5 set wins over same-cycle clear (bank 0 pin 5, either edge)
    wr(12'h700, 32'h5545_3555);
    idle(4);
    @(negedge clk); pins[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 12'hA00; bus_we = 1'b1; bus_wdata = 32'h20;
    @(negedge clk);
    bus_we = 1'b0;
    rd(12'hA00, 32'h20, "R5 set wins over clear");
    wr(12'hA00, 32'h20);
    rd(12'hA00, 32'h00, "R5 clear after race");

    // R6/R7 level high on bank 2 pin 0, masked first
    wr(12'h708, 32'h5555_5551);
    idle(4);
    chk("R7 masked pin keeps irq low", {31'd0, irq_out}, 32'd0);
    rd(12'hA08, 32'h01, "R7 masked pin still latches");
    wr(12'h908, 32'hFE);
    idle(2);
    chk("R7 unmask raises irq", {31'd0, irq_out}, 32'd1);
    wr(12'hA08, 32'h01);
    rd(12'hA08, 32'h01, "R6 level re-sets after clear");
    pins[16] = 1'b0;
    idle(4);
    wr(12'hA08, 32'h01);
    rd(12'hA08, 32'h00, "R6 clear sticks when inactive");
    idle(2);
    chk("R7 irq low after level ends", {31'd0, irq_out}, 32'd0);

    // R3 disabled code on bank 1 pin 2
    wr(12'h704, 32'h5555_5655);
    for (int k = 0; k < 4; k++) begin
      pins[10] = ~pins[10];
      idle(3);
    end
    rd(12'hA04, 32'h00, "R3 disabled code never pends");

    // R3 falling and level low on bank 3 pin 7
    wr(12'h70C, 32'h2555_5555);
    idle(3);
    pins[31] = 1'b0;
    idle(5);
    rd(12'hA0C, 32'h80, "R3 falling sets pin 7");
    wr(12'hA0C, 32'h80);
    rd(12'hA0C, 32'h00, "R3 falling is one-shot");
    wr(12'h70C, 32'h0555_5555);
    idle(3);
    rd(12'hA0C, 32'h80, "R3 level low sets pin 7");
    pins[31] = 1'b1;
    idle(4);
    wr(12'hA0C, 32'h80);
    rd(12'hA0C, 32'h00, "R6 level low clears when high");

    // R9 unmapped space
    rd(12'h710, 32'h0, "R9 out of range bank");
    rd(12'h702, 32'h0, "R9 unaligned read");
    rd(12'h800, 32'h0, "R9 unmapped page");
    rd(12'hB00, 32'h0, "R9 unmapped page B");
    wr(12'h910, 32'h00);
    wr(12'h902, 32'h00);
    rd(12'h900, 32'hF7, "R9 stray write leaves mask 0");
    rd(12'h904, 32'hFF, "R9 stray write leaves mask 1");
    rd(12'h90C, 32'hFF, "R1 mask bank 3 address");

    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule